// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A bank of general-purpose pins, 32 by default, each governed by one 32-bit control word on a simple word-addressed register bus. The control word picks whether the pin is plain GPIO or routes one of three alternate-function peripherals to the pad. It also sets direction, open-drain behaviour, the pull resistor, power gating, the driven level, the source of that level and the interrupt detection mode. Reading a control word returns the configuration together with the synchronized pad level.

Pad inputs pass through a two-flop synchronizer. A third flop keeps the previous synchronized value, and comparing the two finds edges. Each pin drives one interrupt event line to an external aggregator. For edge modes the line carries a one-cycle pulse. For level modes it is held while the level matches. Two further bus words give parallel access: one reads every synchronized input at once, and one holds a per-pin output level that GPIO-mode pins may select instead of their own control bit.

Word map: addresses 0 to NPINS-1 are the pin control words, NPINS is the parallel input word (read-only) and NPINS+1 is the parallel output word.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control word reads 0x0000_0040 (with bit 24 showing the input), and every pin has pad_oe, pad_pu, pad_pd and irq_evt low.
- R2: With mux bits 13:12 = 0, output-select bit 10 = 0 and direction bit 8 = 1, the pin drives pad_oe = 1 and pad_out = control bit 16. With bit 8 = 0 it drives pad_oe = 0.
- R3: In GPIO mode with output-select bit 10 = 1, pad_out takes the pin's bit of the parallel output word (address NPINS+1), which reads back as written.
- R4: A mux value m of 1, 2 or 3 routes alt_dout and alt_doe bit (m-1)*NPINS+i to pad_out and pad_oe of pin i.
- R5: With open-drain bit 9 set, pad_out is always 0 and pad_oe = enable AND NOT data. With the direction as input, the pin never drives, whatever the level.
- R6: Pull field bits 1:0: 01 asserts pad_pu, 10 asserts pad_pd, and 00 or 11 asserts neither. The two are never high together.
- R7: Power field bits 3:2 = 10 turns the pin off: pad_oe, pad_out, pad_pu, pad_pd and irq_evt are all low whatever the other fields hold. Any other value leaves the pin powered.
- R8: Control bit 24 and bit i of the parallel input word (address NPINS) show pad_in bit i as it was two clock edges earlier.
- R9: Detect field bits 7:4 = 1100 (rising), 1101 (falling) or 1110 (both) raise irq_evt for exactly one cycle. That cycle begins at the second clock edge after the matching pad change.
- R10: Detect code 0000 holds irq_evt high while the synchronized level is 0. Code 0001 holds it high while that level is 1.
- R11: Detect code 0100 and every code not named in R9 or R10 keep irq_evt low.
- R12: Only control bits 0-10, 12-13 and 16 are writable, and other bits other than 24 read 0. Writes to the parallel input word or to addresses above NPINS+1 change nothing, and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| alt_dout | input | 3*NPINS | Output data of the three alternate functions, function m-1 in slice m-1 |
| alt_doe | input | 3*NPINS | Output enables of the three alternate functions |
| irq_evt | output | NPINS | Per-pin interrupt event to the aggregator |

## Verification
The hardest case to reach from the ports is the exact timing of edge pulses for every detect code on every pin. A pad change has to be caught in the cycle where the synchronized value differs from the previous one, and codes that are neither edge nor level must stay silent through the whole transition. The bench sweeps all 16 detect codes across all pins. Each time it raises and lowers the pad, it checks irq_evt after every clock edge against an arithmetic model of the two-stage delay. A powered-off pin configured for level-high detection with its pad held high tests whether power gating overrides detection.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // control word field positions
  localparam int B_PULL = 0;   // 2 bits
  localparam int B_PWR  = 2;   // 2 bits
  localparam int B_DET  = 4;   // 4 bits
  localparam int B_DIR  = 8;
  localparam int B_OD   = 9;
  localparam int B_PSEL = 10;
  localparam int B_MUX  = 12;  // 2 bits
  localparam int B_LVL  = 16;
  localparam int B_IN   = 24;

  localparam logic [31:0] CTL_WMASK = 32'h0001_37FF;
  localparam logic [31:0] CTL_RESET = 32'h0000_0040;
  localparam logic [1:0]  PWR_OFF   = 2'b10;

  typedef enum logic [3:0] {
    DET_LVL_LO = 4'b0000,
    DET_LVL_HI = 4'b0001,
    DET_OFF    = 4'b0100,
    DET_RISE   = 4'b1100,
    DET_FALL   = 4'b1101,
    DET_BOTH   = 4'b1110
  } det_e;

  function automatic logic det_hit(input logic [3:0] code, input logic s, input logic p);
    logic hit;
    case (code)
      DET_LVL_LO: hit = !s;
      DET_LVL_HI: hit = s;
      DET_RISE:   hit = s && !p;
      DET_FALL:   hit = !s && p;
      DET_BOTH:   hit = s ^ p;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic pwr_is_off(input logic [1:0] f);
    return f == PWR_OFF;
  endfunction

  // returns {pull_down, pull_up}
  function automatic logic [1:0] pull_dec(input logic [1:0] f);
    logic [1:0] r;
    case (f)
      2'b01:   r = 2'b01;
      2'b10:   r = 2'b10;
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  // returns {oe, out}
  function automatic logic [1:0] od_drive(input logic en, input logic od, input logic data);
    logic [1:0] r;
    if (od) r = {en && !data, 1'b0};
    else    r = {en, data};
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sync_lvl,
  output logic [W-1:0] prev_lvl
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_lvl <= '0;
      prev_lvl <= '0;
    end else begin
      stage1   <= raw;
      sync_lvl <= stage1;
      prev_lvl <= sync_lvl;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [4*W-1:0] det_code,
  input  logic [W-1:0]   armed,
  input  logic [W-1:0]   sync_lvl,
  input  logic [W-1:0]   prev_lvl,
  output logic [W-1:0]   irq_evt
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign irq_evt[i] = armed[i] && det_hit(det_code[4*i +: 4], sync_lvl[i], prev_lvl[i]);
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   pin_off,
  input  logic [W-1:0]   pin_dir,
  input  logic [W-1:0]   pin_od,
  input  logic [W-1:0]   pin_psel,
  input  logic [W-1:0]   pin_lvl,
  input  logic [2*W-1:0] pin_pull,
  input  logic [2*W-1:0] pin_mux,
  input  logic [W-1:0]   par_out,
  input  logic [3*W-1:0] alt_dout,
  input  logic [3*W-1:0] alt_doe,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_pu,
  output logic [W-1:0]   pad_pd
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic       data, en;
    logic [1:0] drv, pl;

    always_comb begin
      case (pin_mux[2*i +: 2])
        2'd1:    begin data = alt_dout[i];       en = alt_doe[i];       end
        2'd2:    begin data = alt_dout[W + i];   en = alt_doe[W + i];   end
        2'd3:    begin data = alt_dout[2*W + i]; en = alt_doe[2*W + i]; end
        default: begin
          data = pin_psel[i] ? par_out[i] : pin_lvl[i];
          en   = pin_dir[i];
        end
      endcase
      drv = od_drive(en, pin_od[i], data);
      pl  = pull_dec(pin_pull[2*i +: 2]);
    end

    assign pad_oe[i]  = !pin_off[i] && drv[1];
    assign pad_out[i] = !pin_off[i] && drv[0];
    assign pad_pu[i]  = !pin_off[i] && pl[0];
    assign pad_pd[i]  = !pin_off[i] && pl[1];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int AW   = $clog2(NPINS + 2),
  localparam int PIDX = $clog2(NPINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_pu,
  output logic [NPINS-1:0]   pad_pd,
  input  logic [3*NPINS-1:0] alt_dout,
  input  logic [3*NPINS-1:0] alt_doe,
  output logic [NPINS-1:0]   irq_evt
);
  localparam logic [AW-1:0] A_PARIN  = AW'(NPINS);
  localparam logic [AW-1:0] A_PAROUT = AW'(NPINS + 1);

  logic [31:0]        ctl_q [NPINS];
  logic [NPINS-1:0]   par_out_q;
  logic [NPINS-1:0]   sync_lvl, prev_lvl;

  // decoded per-pin fields, named for the checker
  logic [NPINS-1:0]   pin_off, pin_dir, pin_od, pin_psel, pin_lvl;
  logic [2*NPINS-1:0] pin_pull, pin_mux;
  logic [4*NPINS-1:0] det_code;

  for (genvar i = 0; i < NPINS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ctl_q[i] <= CTL_RESET;
      else if (bus_we && bus_addr == AW'(i))     ctl_q[i] <= bus_wdata & CTL_WMASK;
    end
    assign pin_off[i]          = pwr_is_off(ctl_q[i][B_PWR +: 2]);
    assign pin_dir[i]          = ctl_q[i][B_DIR];
    assign pin_od[i]           = ctl_q[i][B_OD];
    assign pin_psel[i]         = ctl_q[i][B_PSEL];
    assign pin_lvl[i]          = ctl_q[i][B_LVL];
    assign pin_pull[2*i +: 2]  = ctl_q[i][B_PULL +: 2];
    assign pin_mux[2*i +: 2]   = ctl_q[i][B_MUX +: 2];
    assign det_code[4*i +: 4]  = ctl_q[i][B_DET +: 4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             par_out_q <= '0;
    else if (bus_we && bus_addr == A_PAROUT) par_out_q <= bus_wdata[NPINS-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_PARIN) begin
      bus_rdata        = ctl_q[bus_addr[PIDX-1:0]];
      bus_rdata[B_IN]  = sync_lvl[bus_addr[PIDX-1:0]];
    end else if (bus_addr == A_PARIN) begin
      bus_rdata = 32'(sync_lvl);
    end else if (bus_addr == A_PAROUT) begin
      bus_rdata = 32'(par_out_q);
    end
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (pad_in),
    .sync_lvl (sync_lvl),
    .prev_lvl (prev_lvl)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .det_code (det_code),
    .armed    (~pin_off),
    .sync_lvl (sync_lvl),
    .prev_lvl (prev_lvl),
    .irq_evt  (irq_evt)
  );

  gpio_pin_drive #(.W(NPINS)) u_drv (
    .pin_off  (pin_off),
    .pin_dir  (pin_dir),
    .pin_od   (pin_od),
    .pin_psel (pin_psel),
    .pin_lvl  (pin_lvl),
    .pin_pull (pin_pull),
    .pin_mux  (pin_mux),
    .par_out  (par_out_q),
    .alt_dout (alt_dout),
    .alt_doe  (alt_doe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPINS-1:0]   pad_in,
  input logic [NPINS-1:0]   sync_lvl,
  input logic [NPINS-1:0]   prev_lvl,
  input logic [NPINS-1:0]   pin_off,
  input logic [NPINS-1:0]   pin_od,
  input logic [4*NPINS-1:0] det_code,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_pu,
  input logic [NPINS-1:0]   pad_pd,
  input logic [NPINS-1:0]   irq_evt
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_off[i] |-> !pad_oe[i] && !pad_out[i] && !pad_pu[i] && !pad_pd[i] && !irq_evt[i]);

    assert_od_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_od[i] |-> !pad_out[i]);

    assert_pull_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu[i] && pad_pd[i]));

    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> sync_lvl[i] == $past(pad_in[i], 2));

    assert_rise_then_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_evt[i] && det_code[4*i +: 4] == DET_RISE) |=> prev_lvl[i]);

    assert_fall_then_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_evt[i] && det_code[4*i +: 4] == DET_FALL) |=> !prev_lvl[i]);

    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (det_code[4*i +: 4] == DET_OFF) |-> !irq_evt[i]);
  end
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pad_in   (pad_in),
  .sync_lvl (sync_lvl),
  .prev_lvl (prev_lvl),
  .pin_off  (pin_off),
  .pin_od   (pin_od),
  .det_code (det_code),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pad_pu   (pad_pu),
  .pad_pd   (pad_pd),
  .irq_evt  (irq_evt)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int N  = 32;
  localparam int AW = $clog2(N + 2);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_we;
  logic [AW-1:0]  bus_addr;
  logic [31:0]    bus_wdata, bus_rdata;
  logic [N-1:0]   pad_in, pad_out, pad_oe, pad_pu, pad_pd, irq_evt;
  logic [3*N-1:0] alt_dout, alt_doe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.NPINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .alt_dout(alt_dout), .alt_doe(alt_doe), .irq_evt(irq_evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #0.5;
    d = bus_rdata;
  endtask

  // independent model of the detection modes
  function automatic bit model_hit(input int code, input bit s, input bit p);
    if (code == 0)  return !s;
    if (code == 1)  return s;
    if (code == 12) return s && !p;
    if (code == 13) return p && !s;
    if (code == 14) return s != p;
    return 0;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt_dout = '0; alt_doe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step();

    // R1: reset state
    for (int i = 0; i < N; i++) begin
      rd(i, d); chk("R1 ctl reset", d, 32'h40);
    end
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pulls", pad_pu | pad_pd, '0);
    chk("R1 irq", irq_evt, '0);

    // R12: writable mask and address decode
    wr(5, 32'hFFFF_FFFF); rd(5, d); chk("R12 mask", d, 32'h0001_37FF);
    wr(5, 32'h40);
    wr(N, 32'hFFFF_FFFF); rd(N, d); chk("R12 parin ro", d, 32'h0);
    wr(N + 5, 32'h0000_1234); rd(N + 5, d); chk("R12 hole read", d, 32'h0);
    rd(0, d); chk("R12 hole write", d, 32'h40);

    // R2: GPIO output from control bit 16
    for (int i = 0; i < N; i++) begin
      wr(i, 32'h0001_0140);
      chk("R2 out high", pad_out, 32'(1) << i);
      chk("R2 oe", pad_oe, 32'(1) << i);
      wr(i, 32'h0000_0140);
      chk("R2 out low", pad_out, '0);
      wr(i, 32'h0000_0040);
      chk("R2 input no drive", pad_oe, '0);
    end

    // R3: parallel output source
    wr(N + 1, 32'hA5A5_3C3C); rd(N + 1, d); chk("R3 readback", d, 32'hA5A5_3C3C);
    for (int i = 0; i < N; i++) wr(i, 32'h0000_0540);
    chk("R3 pad_out", pad_out, 32'hA5A5_3C3C);
    chk("R3 pad_oe", pad_oe, 32'hFFFF_FFFF);
    wr(N + 1, 32'h0F0F_F00F);
    chk("R3 pad_out 2", pad_out, 32'h0F0F_F00F);

    // R4: alternate functions
    alt_dout = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666};
    alt_doe  = {32'hF0F0_0F0F, 32'h00FF_FF00, 32'h8421_1248};
    for (int m = 1; m <= 3; m++) begin
      for (int i = 0; i < N; i++) wr(i, 32'h40 | (32'(m) << 12));
      chk("R4 alt data", pad_out, alt_dout[32*(m-1) +: 32]);
      chk("R4 alt oe", pad_oe, alt_doe[32*(m-1) +: 32]);
    end
    for (int i = 0; i < N; i++) wr(i, 32'h40);

    // R5: open drain
    wr(3, 32'h0001_0240);
    chk("R5 od input lvl1 oe", pad_oe, '0);
    wr(3, 32'h0001_0340);
    chk("R5 od out lvl1 oe", pad_oe, '0);
    chk("R5 od out lvl1 data", pad_out, '0);
    wr(3, 32'h0000_0340);
    chk("R5 od out lvl0 oe", pad_oe, 32'h8);
    chk("R5 od out lvl0 data", pad_out, '0);
    wr(3, 32'h0000_0240);
    chk("R5 od input lvl0 oe", pad_oe, '0);
    wr(3, 32'h40);

    // R6: pulls
    for (int p = 0; p < 4; p++) begin
      wr(9, 32'h40 | 32'(p));
      chk("R6 pull up", pad_pu, (p == 1) ? 32'h200 : 32'h0);
      chk("R6 pull down", pad_pd, (p == 2) ? 32'h200 : 32'h0);
    end
    wr(9, 32'h40);

    // R7: power off overrides drive, pulls and detection
    pad_in[12] = 1'b1; repeat (3) step();
    wr(12, 32'h0001_0119);           // off, dir out, lvl 1, pull-up, level-high
    chk("R7 off oe", pad_oe, '0);
    chk("R7 off out", pad_out, '0);
    chk("R7 off pull", pad_pu, '0);
    chk("R7 off irq", irq_evt, '0);
    wr(12, 32'h0001_0111);           // powered, same otherwise
    chk("R7 on oe", pad_oe, 32'h1000);
    chk("R7 on pull", pad_pu, 32'h1000);
    chk("R7 on irq", irq_evt, 32'h1000);
    wr(12, 32'h40);
    pad_in[12] = 1'b0; repeat (3) step();

    // R8: two-stage synchronizer
    pad_in = 32'h1234_5678;
    step();
    rd(N, d); chk("R8 one edge", d, 32'h0);
    step();
    rd(N, d); chk("R8 two edges", d, 32'h1234_5678);
    rd(4, d); chk("R8 bit24", d, 32'h0100_0040);
    rd(0, d); chk("R8 bit24 zero", d, 32'h0000_0040);
    pad_in = '0; repeat (3) step();

    // R9 / R10 / R11: every detect code on every pin
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 16; c++) begin
        string tg;
        tg = (c >= 12 && c <= 14) ? "R9 edge" : (c <= 1) ? "R10 level" : "R11 silent";
        wr(i, 32'(c) << 4);
        step();
        chk(tg, irq_evt, model_hit(c, 0, 0) ? (32'(1) << i) : 32'h0);
        pad_in[i] = 1'b1;
        for (int k = 1; k <= 4; k++) begin
          step();
          chk(tg, irq_evt, model_hit(c, k >= 2, k >= 3) ? (32'(1) << i) : 32'h0);
        end
        pad_in[i] = 1'b0;
        for (int k = 1; k <= 3; k++) begin
          step();
          chk(tg, irq_evt, model_hit(c, k < 2, k < 3) ? (32'(1) << i) : 32'h0);
        end
        wr(i, 32'h40);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule